// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block supervises a processor by timing the gap between its signs of life. Software loads an 8-bit control register that holds a steering bit, a 5-bit multiplier and a 2-bit resolution code. The timer counts a 1/16-second time-base tick, scaled to the chosen resolution. It starts the period again whenever the register is written or the kick input changes level in either direction.

If the period runs out, the block sets a watchdog flag. It then does one of two things. With steering clear, it raises an interrupt request that stays up until software writes 0x00 to the register. With steering set, it drives a low-going reset pulse of fixed length, clears its own register and issues a one-cycle request to clear the frequency-test control bit. A read strobe on the flags location clears the flag. A synchronous reset models power-down: it disables the timer and clears the register. A register whose multiplier is zero never times out.

Top module: `wd_steer_top`

## Requirements
- R1: After reset the register reads 0x00, the flag and the interrupt are low, the reset output is high and the frequency-test clear is low.
- R2: Register bit 7 is the steering bit, bits 6..2 are the multiplier M and bits 1..0 are the resolution code C. The timeout is reached on the (M x 4^C)-th time-base tick after the last restart, so the codes 0, 1, 2 and 3 mean 1/16 s, 1/4 s, 1 s and 4 s. The flag is not set one tick earlier.
- R3: Any write to the register, including a write of the value it already holds, restarts the whole period.
- R4: A rising edge on the kick input restarts the period, and so does a falling edge. The input passes through two synchronizer flops first.
- R5: A register of 0x00, or any value with M = 0, never sets the flag, raises the interrupt or pulses the reset output.
- R6: A timeout with steering bit 0 sets the flag and raises the interrupt in the same cycle.
- R7: A timeout with steering bit 1 sets the flag, holds the interrupt low and drives the reset output low for exactly PULSE_CYCLES clock cycles.
- R8: A timeout with steering bit 1 clears the register to 0x00 and pulses the frequency-test clear for one cycle at the edge where the reset output falls. After that the timer stays disabled.
- R9: A flags-read strobe clears the flag and leaves the interrupt unchanged.
- R10: The interrupt is cleared only by a register write of 0x00. A nonzero write leaves it asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, also used as power-down |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| flag_rd | input | 1 | Flags-register read strobe, clears the flag |
| kick | input | 1 | Asynchronous kick input, either edge restarts |
| tick16 | input | 1 | One-cycle pulse every 1/16 s |
| cfg_q | output | 8 | Current register contents |
| wd_flag | output | 1 | Watchdog timeout flag |
| irq | output | 1 | Interrupt request, active high |
| rst_pulse_n | output | 1 | Reset pulse output, active low |
| ft_clr | output | 1 | One-cycle request to clear the frequency-test bit |

## Verification
A prescaler or period counter left in the wrong state moves the timeout by at least one tick. The flag then rises one tick early or late, and the sweep over every multiplier and resolution pair catches this at the first timeout of that pair. A restart that does not reach one of the two counters shows up the same way, one full resolution unit or more away from the expected tick. A steering or clearing fault is visible in the cycle after the timeout edge: the interrupt or the reset output is wrong, or the register fails to read zero. A pulse counter that is off by one shows up when the reset output rises again.

// File: rtl/wd_pkg.sv
// Package: shared widths, the register layout and the resolution divider.
// Assumes the resolution code selects a divider of 4^code time-base ticks.
package wd_pkg;
    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    localparam int PRE_W  = 2 * ((1 << RES_W) - 1);

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_cfg_t;

    // Last prescaler count for a resolution code: 4^code - 1.
    function automatic logic [PRE_W-1:0] res_last(input logic [RES_W-1:0] code);
        logic [PRE_W:0] span;
        span = ((PRE_W+1)'(1) << (2 * code)) - (PRE_W+1)'(1);
        return span[PRE_W-1:0];
    endfunction
endpackage

// File: rtl/wd_kick_sync.sv
// Kick synchronizer: STAGES flops bring the kick into the clock domain,
// then one more flop gives a pulse on either edge.
// Assumes STAGES >= 2 and an asynchronous, slowly changing kick.
module wd_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic kick_edge
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the raw kick through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], kick};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign kick_edge = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wd_prescale.sv
// Resolution prescaler: divides the 1/16 s tick by 4^code and emits
// one pulse per resolution unit. Restart returns it to the start of a unit.
module wd_prescale
    import wd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [RES_W-1:0] res,
    output logic             res_tick
);
    logic [PRE_W-1:0] pre_q;
    logic             at_last;

    assign at_last  = (pre_q == res_last(res));
    assign res_tick = tick && at_last;

    // Count time-base ticks within one resolution unit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) pre_q <= '0;
        else if (tick)         pre_q <= at_last ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/wd_period.sv
// Period counter: counts resolution units up to the multiplier and flags
// expiry. A zero multiplier holds it idle. A restart wins over an expiry.
module wd_period
    import wd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              res_tick,
    input  logic [MULT_W-1:0] mult,
    output logic              expire
);
    logic [MULT_W-1:0] unit_q;
    logic              at_end;

    assign at_end = (unit_q == mult - 1'b1);
    assign expire = res_tick && (mult != '0) && at_end && !restart;

    // Count elapsed resolution units since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || mult == '0) unit_q <= '0;
        else if (res_tick)                   unit_q <= at_end ? '0 : unit_q + 1'b1;
    end
endmodule

// File: rtl/wd_pulse.sv
// Reset pulse generator: on fire, holds pulse_n low for PULSE_CYCLES clocks.
// Assumes fire does not repeat while a pulse is running (the register clears).
module wd_pulse #(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse_n
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    logic [CW-1:0] left_q;

    // Load the length on fire, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             left_q <= '0;
        else if (fire)          left_q <= CW'(PULSE_CYCLES);
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign pulse_n = (left_q == '0);
endmodule

// File: rtl/wd_steer_top.sv
// Steerable watchdog: control register, restart logic, expiry steering to
// an interrupt or a reset pulse, and the timeout flag.
// Assumes tick16 is a one-cycle pulse and the reset doubles as power-down.
module wd_steer_top
    import wd_pkg::*;
#(
    parameter int PULSE_CYCLES = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       flag_rd,
    input  logic       kick,
    input  logic       tick16,
    output logic [7:0] cfg_q,
    output logic       wd_flag,
    output logic       irq,
    output logic       rst_pulse_n,
    output logic       ft_clr
);
    wd_cfg_t cfg_r;
    logic    kick_edge, restart, res_tick, expire;

    assign restart = cfg_we || kick_edge;
    assign cfg_q   = cfg_r;

    wd_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .kick(kick), .kick_edge(kick_edge));

    wd_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick16),
        .res(cfg_r.res), .res_tick(res_tick));

    wd_period u_per (
        .clk(clk), .rst_n(rst_n), .restart(restart), .res_tick(res_tick),
        .mult(cfg_r.mult), .expire(expire));

    wd_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(expire && cfg_r.steer),
        .pulse_n(rst_pulse_n));

    // Control register: software write, or self-clear after a reset-steered expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cfg_r <= '0;
        else if (cfg_we)                cfg_r <= wd_cfg_t'(cfg_wdata);
        else if (expire && cfg_r.steer) cfg_r <= '0;
    end

    // Timeout flag: set on expiry, cleared by a flags read.
    always_ff @(posedge clk) begin
        if (!rst_n)       wd_flag <= 1'b0;
        else if (expire)  wd_flag <= 1'b1;
        else if (flag_rd) wd_flag <= 1'b0;
    end

    // Interrupt: set on interrupt-steered expiry, released only by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                               irq <= 1'b0;
        else if (cfg_we && cfg_wdata == 8'h00)    irq <= 1'b0;
        else if (expire && !cfg_r.steer)          irq <= 1'b1;
    end

    // One-cycle frequency-test clear request on a reset-steered expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) ft_clr <= 1'b0;
        else        ft_clr <= expire && cfg_r.steer;
    end
endmodule

// File: rtl/wd_steer_chk.sv
// Checker for wd_steer_top: port-level timing properties, bound below.
module wd_steer_chk #(
    parameter int PULSE_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic       flag_rd,
    input logic [7:0] cfg_q,
    input logic       wd_flag,
    input logic       irq,
    input logic       rst_pulse_n,
    input logic       ft_clr
);
    int low_cnt;

    // Count cycles spent with the reset output low.
    always_ff @(posedge clk) begin
        if (!rst_n)            low_cnt <= 0;
        else if (!rst_pulse_n) low_cnt <= low_cnt + 1;
        else                   low_cnt <= 0;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (cfg_q == 8'h00 && !wd_flag && !irq && rst_pulse_n && !ft_clr));

    // R5
    zero_mult_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[6:2] == 5'd0) |=> !$rose(wd_flag));

    // R6
    irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> wd_flag);

    // R7
    pulse_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse_n) |-> (low_cnt == PULSE_CYCLES));

    // R8
    pulse_clears_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pulse_n) |-> (cfg_q == 8'h00 && ft_clr && wd_flag));

    // R9
    flag_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_flag) |-> $past(flag_rd));

    // R10
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(cfg_we && cfg_wdata == 8'h00));
endmodule

bind wd_steer_top wd_steer_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .flag_rd(flag_rd), .cfg_q(cfg_q), .wd_flag(wd_flag), .irq(irq),
    .rst_pulse_n(rst_pulse_n), .ft_clr(ft_clr));

// File: tb/tb_wd_steer_top.sv
module tb_wd_steer_top;
    localparam int PULSE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       flag_rd = 1'b0;
    logic       kick = 1'b0;
    logic       tick16 = 1'b0;
    logic [7:0] cfg_q;
    logic       wd_flag, irq, rst_pulse_n, ft_clr;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    wd_steer_top #(.PULSE_CYCLES(PULSE), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .flag_rd(flag_rd), .kick(kick), .tick16(tick16), .cfg_q(cfg_q),
        .wd_flag(wd_flag), .irq(irq), .rst_pulse_n(rst_pulse_n), .ft_clr(ft_clr));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic read_flags();
        @(negedge clk); flag_rd = 1'b1;
        @(negedge clk); flag_rd = 1'b0;
    endtask

    // Hold tick16 high across n rising edges, ending on a falling edge.
    task automatic ticks(input int n);
        if (n > 0) begin
            tick16 = 1'b1;
            repeat (n) @(negedge clk);
            tick16 = 1'b0;
        end
    endtask

    task automatic toggle_kick();
        @(negedge clk); kick = ~kick;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cfg", cfg_q, 0);
        check("R1 flag", wd_flag, 0);
        check("R1 irq", irq, 0);
        check("R1 rst", rst_pulse_n, 1);
        check("R1 ft", ft_clr, 0);

        // R2 / R6 sweep over every multiplier and resolution, interrupt steering
        for (int c = 0; c < 4; c++) begin
            for (int m = 1; m < 32; m++) begin
                automatic int span = m * (1 << (2 * c));
                write_cfg({1'b0, 5'(m), 2'(c)});
                ticks(span - 1);
                check("R2 early", wd_flag, 0);
                ticks(1);
                check("R2 on time", wd_flag, 1);
                check("R6 irq", irq, 1);
                check("R6 rst high", rst_pulse_n, 1);
                read_flags();
                write_cfg(8'h00);
            end
        end

        // R9 / R10 on interrupt steering
        write_cfg(8'h04);            // M=1, C=0
        ticks(1);
        check("R6 flag", wd_flag, 1);
        read_flags();
        check("R9 flag cleared", wd_flag, 0);
        check("R9 irq kept", irq, 1);
        write_cfg(8'h0E);
        check("R10 nonzero write keeps irq", irq, 1);
        write_cfg(8'h00);
        check("R10 zero write clears irq", irq, 0);

        // R3 rewrite restarts: 0x0E is M=3, C=2 -> 48 ticks
        write_cfg(8'h0E);
        ticks(40);
        write_cfg(8'h0E);
        ticks(47);
        check("R3 restart by write", wd_flag, 0);
        ticks(1);
        check("R3 full period after write", wd_flag, 1);
        read_flags(); write_cfg(8'h00);

        // R4 kick edges restart: 0x08 is M=2, C=0 -> 2 ticks
        write_cfg(8'h08);
        ticks(1);
        toggle_kick();               // rising
        ticks(1);
        check("R4 rising edge restart", wd_flag, 0);
        toggle_kick();               // falling
        ticks(1);
        check("R4 falling edge restart", wd_flag, 0);
        ticks(1);
        check("R4 expiry after kick", wd_flag, 1);
        read_flags(); write_cfg(8'h00);

        // R5 disabled configurations
        ticks(300);
        check("R5 zero reg no flag", wd_flag, 0);
        write_cfg(8'h83);            // steer, M=0, C=3
        ticks(300);
        check("R5 zero mult no flag", wd_flag, 0);
        check("R5 zero mult no pulse", rst_pulse_n, 1);
        check("R5 zero mult no irq", irq, 0);

        // R7 / R8 reset steering: 0x84 is steer, M=1, C=0
        write_cfg(8'h84);
        ticks(1);
        check("R7 flag", wd_flag, 1);
        check("R7 irq low", irq, 0);
        check("R7 pulse low", rst_pulse_n, 0);
        check("R8 cfg cleared", cfg_q, 0);
        check("R8 ft clear", ft_clr, 1);
        begin
            int low = 1;
            @(negedge clk);
            check("R8 ft one cycle", ft_clr, 0);
            while (!rst_pulse_n && low < 1000) begin
                low++;
                @(negedge clk);
            end
            check("R7 pulse length", low, PULSE);
        end
        read_flags();
        ticks(300);
        check("R8 stays disabled", wd_flag, 0);
        check("R8 no second pulse", rst_pulse_n, 1);

        // R1 reset as power-down clears a loaded register
        write_cfg(8'h8E);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 power-down clears cfg", cfg_q, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule